// File: doc/BRIEF.md
# Strip-Sequenced Frame Burst Controller

This block moves a video frame that lives in external memory through an overlay engine, one full-width horizontal strip at a time. After a start request, it issues burst reads that fill a local buffer with one strip. It then streams the buffered words to the overlay engine and stores each returned word back in place. Finally, it issues burst writes that return the modified strip to a separate output frame area in external memory. The next strip follows the same three phases. When the last strip has been written, a one-cycle done pulse tells the host that the frame is finished.

The memory side is a simplified burst port. It has a read-request channel and a write-request channel, each carrying a byte address and a beat count. The read data is a beat stream that is always accepted. The write data is a beat stream with a ready signal. One beat is one `DATA_W`-bit word. At the default 512-bit width, one beat holds 20 pixels of 24 bits. The frame geometry (words per row, rows per strip, strip count) and the burst cap are parameters, so a smaller frame can be used in simulation. By default a strip is 96 words by 54 rows and a frame is 20 strips.

Top module: `strip_burst_seq`

## Requirements
- R1: While reset is low, and from the first clock after reset, `done`, `rd_req_valid`, `wr_req_valid`, `wr_data_valid` and `ovl_out_valid` are 0. This applies to a reset in the middle of a frame as well, and a later start runs a whole frame correctly.
- R2: The read requests of a strip are split as follows:
  - The first request starts at the strip's base byte address.
  - Each request carries a beat count between 1 and `MAX_BURST`.
  - Each request starts at the previous address plus the previous count times `DATA_W/8`.
  - Every request except the last of a strip carries exactly `MAX_BURST` beats.
  - The counts add up to `WORDS_PER_ROW*ROWS_PER_STRIP`.
- R3: A pending request keeps its valid, address and count unchanged until it is accepted. The next request of the same phase is offered only after the previous one has been accepted.
- R4: No word goes to the overlay engine until every read beat of the current strip has arrived. Words leave in the order they arrived, and a word that is not accepted stays unchanged on `ovl_out_data`.
- R5: Words returned by the overlay engine replace the buffered words in order. They go out as write data in that same order, and a write beat that is not accepted stays unchanged.
- R6: The base address of strip n (counting from 0) is set as follows:
  - For reads, it is the latched input base plus n·`WORDS_PER_ROW`·`ROWS_PER_STRIP`·`DATA_W/8`.
  - For writes, it is the latched output base plus the same offset.
  - The write requests are split by the same rule as R2.
- R7: `done` is high for exactly one cycle. It comes after all write beats and write requests of the last strip have been accepted, and the block then returns to idle.
- R8: A start that arrives while a frame is in progress has no effect, and neither does a change on `in_base` or `out_base`. After `done`, no further request appears until a new start.
- R9: The phases never overlap:
  - No read request for strip n+1 is offered before every write beat of strip n has been accepted.
  - No write request for a strip is offered before every overlay result of that strip has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a frame (sampled only when idle) |
| in_base | input | ADDR_W | Byte address of the source frame |
| out_base | input | ADDR_W | Byte address of the destination frame |
| done | output | 1 | One-cycle pulse when the frame is finished |
| rd_req_valid | output | 1 | Read request offered |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Read request byte address |
| rd_req_len | output | LEN_W | Read request beat count (1..MAX_BURST) |
| rd_data_valid | input | 1 | Read data beat present (always taken) |
| rd_data | input | DATA_W | Read data beat |
| wr_req_valid | output | 1 | Write request offered |
| wr_req_ready | input | 1 | Write request accepted |
| wr_req_addr | output | ADDR_W | Write request byte address |
| wr_req_len | output | LEN_W | Write request beat count (1..MAX_BURST) |
| wr_data_valid | output | 1 | Write data beat offered |
| wr_data_ready | input | 1 | Write data beat accepted |
| wr_data | output | DATA_W | Write data beat |
| ovl_out_valid | output | 1 | Word offered to the overlay engine |
| ovl_out_ready | input | 1 | Overlay engine takes the word |
| ovl_out_data | output | DATA_W | Word to the overlay engine |
| ovl_in_valid | input | 1 | Result word from the overlay engine |
| ovl_in_ready | output | 1 | Controller accepts result words |
| ovl_in_data | input | DATA_W | Result word |

## Verification
The hardest situations to reach from the ports are the seams between phases and the short tail burst at the end of each strip. Examples are a write request that becomes pending just as the last overlay result lands, and a read request for the next strip that could start while write beats are still stalled. The bench shrinks the frame so that each strip needs two full bursts and one short burst. It then drives every ready and valid input from rotating stall masks, with a different rotation per channel, so that the stalls land on different sides of each seam from one frame to the next. Some frames also carry a start pulse and altered base inputs in mid-flight, and one frame is cut by reset.

// File: rtl/strip_seq_pkg.sv
// Shared types for the strip burst sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package strip_seq_pkg;

    // Control phases of one frame pass.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_READ    = 3'd1,
        ST_PROCESS = 3'd2,
        ST_WRITE   = 3'd3,
        ST_NEXT    = 3'd4,
        ST_DONE    = 3'd5
    } seq_state_t;

endpackage

// File: rtl/sts_burst_issuer.sv
// Burst request generator: on a launch pulse it splits TOTAL_BEATS beats
// into requests of at most MAX_BURST beats, walking the byte address.
// Assumes: launch only arrives while no request is pending; one request
// is offered at a time and held until accepted.
module sts_burst_issuer #(
    parameter int ADDR_W         = 32,
    parameter int TOTAL_BEATS    = 5184,
    parameter int MAX_BURST      = 256,
    parameter int BYTES_PER_BEAT = 64,
    localparam int CNT_W         = $clog2(TOTAL_BEATS + 1),
    localparam int LEN_W         = $clog2(MAX_BURST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LEN_W-1:0]  req_len
);

    logic [CNT_W-1:0]  remain_q;
    logic [ADDR_W-1:0] addr_q;
    logic              valid_q;
    logic [LEN_W-1:0]  len_c;
    logic              fire;

    // Size of the pending request: the cap or whatever is left.
    always_comb begin
        if (32'(remain_q) > MAX_BURST) len_c = LEN_W'(MAX_BURST);
        else                           len_c = LEN_W'(remain_q);
    end

    assign fire = valid_q && req_ready;

    // Request state: arm on launch, step address and remainder on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            remain_q <= '0;
            addr_q   <= '0;
        end else if (launch) begin
            valid_q  <= 1'b1;
            remain_q <= CNT_W'(TOTAL_BEATS);
            addr_q   <= base_addr;
        end else if (fire) begin
            remain_q <= remain_q - CNT_W'(len_c);
            addr_q   <= addr_q + ADDR_W'(len_c) * ADDR_W'(BYTES_PER_BEAT);
            valid_q  <= (remain_q != CNT_W'(len_c));
        end
    end

    assign req_valid = valid_q;
    assign req_addr  = addr_q;
    assign req_len   = len_c;

    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len != '0) && (32'(req_len) <= MAX_BURST)); // R2
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_len))); // R3
    AST_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !req_valid); // R3

endmodule

// File: rtl/sts_strip_buffer.sv
// Local strip store: one synchronous write port, one combinational read port.
// Assumes: the caller never reads an index it is writing in the same cycle
// and only trusts read data for indices below DEPTH.
module sts_strip_buffer #(
    parameter int DEPTH  = 5184,
    parameter int DATA_W = 512,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one word per cycle.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            AST_WR_INDEX: assert (32'(wr_idx) < DEPTH); // R4
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/strip_burst_seq.sv
// Frame sequencer: for each full-width strip, burst-read it into the local
// buffer, stream it through the overlay engine (results land in place), then
// burst-write it to the output frame. Pulses done after the last strip.
// Assumes: read data for a phase arrives only after its requests, in address
// order; the overlay engine returns exactly one result per word, in order.
module strip_burst_seq
    import strip_seq_pkg::*;
#(
    parameter int ADDR_W         = 32,
    parameter int DATA_W         = 512,
    parameter int WORDS_PER_ROW  = 96,
    parameter int ROWS_PER_STRIP = 54,
    parameter int STRIP_COUNT    = 20,
    parameter int MAX_BURST      = 256,
    localparam int LEN_W         = $clog2(MAX_BURST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] in_base,
    input  logic [ADDR_W-1:0] out_base,
    output logic              done,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    output logic [LEN_W-1:0]  rd_req_len,
    input  logic              rd_data_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_req_valid,
    input  logic              wr_req_ready,
    output logic [ADDR_W-1:0] wr_req_addr,
    output logic [LEN_W-1:0]  wr_req_len,
    output logic              wr_data_valid,
    input  logic              wr_data_ready,
    output logic [DATA_W-1:0] wr_data,
    output logic              ovl_out_valid,
    input  logic              ovl_out_ready,
    output logic [DATA_W-1:0] ovl_out_data,
    input  logic              ovl_in_valid,
    output logic              ovl_in_ready,
    input  logic [DATA_W-1:0] ovl_in_data
);

    localparam int STRIP_WORDS    = WORDS_PER_ROW * ROWS_PER_STRIP;
    localparam int BYTES_PER_WORD = DATA_W / 8;
    localparam int STRIP_BYTES    = STRIP_WORDS * BYTES_PER_WORD;
    localparam int IDX_W          = $clog2(STRIP_WORDS + 1);
    localparam int BUF_AW         = (STRIP_WORDS > 1) ? $clog2(STRIP_WORDS) : 1;
    localparam int SIDX_W         = $clog2(STRIP_COUNT + 1);

    seq_state_t        state_q;
    logic [SIDX_W-1:0] strip_q;
    logic [ADDR_W-1:0] rd_base_q;
    logic [ADDR_W-1:0] wr_base_q;
    logic              rd_launch_q;
    logic              wr_launch_q;
    logic [IDX_W-1:0]  fill_cnt_q;
    logic [IDX_W-1:0]  send_cnt_q;
    logic [IDX_W-1:0]  ret_cnt_q;
    logic [IDX_W-1:0]  drain_cnt_q;

    logic              buf_wr_en;
    logic [BUF_AW-1:0] buf_wr_idx;
    logic [DATA_W-1:0] buf_wr_data;
    logic [BUF_AW-1:0] buf_rd_idx;
    logic [DATA_W-1:0] buf_rd_data;

    logic in_read, in_proc, in_write;
    logic read_last, proc_last, write_finished;
    logic send_fire, drain_fire;

    // Phase decodes and end-of-phase conditions.
    always_comb begin
        in_read   = (state_q == ST_READ);
        in_proc   = (state_q == ST_PROCESS);
        in_write  = (state_q == ST_WRITE);
        read_last = in_read && rd_data_valid && (fill_cnt_q == IDX_W'(STRIP_WORDS - 1));
        proc_last = in_proc && ovl_in_valid && (ret_cnt_q == IDX_W'(STRIP_WORDS - 1));
        write_finished = in_write && !wr_launch_q && !wr_req_valid
                         && (drain_cnt_q == IDX_W'(STRIP_WORDS));
    end

    // Stream-side handshakes toward the overlay engine and the write port.
    always_comb begin
        ovl_out_valid = in_proc && (send_cnt_q != IDX_W'(STRIP_WORDS));
        ovl_in_ready  = in_proc;
        wr_data_valid = in_write && (drain_cnt_q != IDX_W'(STRIP_WORDS));
        send_fire     = ovl_out_valid && ovl_out_ready;
        drain_fire    = wr_data_valid && wr_data_ready;
    end

    // Buffer port steering: memory fill or overlay results in, overlay or write out.
    always_comb begin
        buf_wr_en   = (in_read && rd_data_valid) || (in_proc && ovl_in_valid);
        buf_wr_idx  = in_read ? BUF_AW'(fill_cnt_q) : BUF_AW'(ret_cnt_q);
        buf_wr_data = in_read ? rd_data : ovl_in_data;
        buf_rd_idx  = in_write ? BUF_AW'(drain_cnt_q) : BUF_AW'(send_cnt_q);
    end

    assign ovl_out_data = buf_rd_data;
    assign wr_data      = buf_rd_data;
    assign done         = (state_q == ST_DONE);

    // Phase sequencing, strip stepping and per-phase word counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            strip_q     <= '0;
            rd_base_q   <= '0;
            wr_base_q   <= '0;
            rd_launch_q <= 1'b0;
            wr_launch_q <= 1'b0;
            fill_cnt_q  <= '0;
            send_cnt_q  <= '0;
            ret_cnt_q   <= '0;
            drain_cnt_q <= '0;
        end else begin
            rd_launch_q <= 1'b0;
            wr_launch_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        rd_base_q   <= in_base;
                        wr_base_q   <= out_base;
                        strip_q     <= '0;
                        fill_cnt_q  <= '0;
                        rd_launch_q <= 1'b1;
                        state_q     <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (rd_data_valid) fill_cnt_q <= fill_cnt_q + 1'b1;
                    if (read_last) begin
                        send_cnt_q <= '0;
                        ret_cnt_q  <= '0;
                        state_q    <= ST_PROCESS;
                    end
                end
                ST_PROCESS: begin
                    if (send_fire)    send_cnt_q <= send_cnt_q + 1'b1;
                    if (ovl_in_valid) ret_cnt_q  <= ret_cnt_q + 1'b1;
                    if (proc_last) begin
                        drain_cnt_q <= '0;
                        wr_launch_q <= 1'b1;
                        state_q     <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (drain_fire)     drain_cnt_q <= drain_cnt_q + 1'b1;
                    if (write_finished) state_q     <= ST_NEXT;
                end
                ST_NEXT: begin
                    if (strip_q == SIDX_W'(STRIP_COUNT - 1)) begin
                        state_q <= ST_DONE;
                    end else begin
                        strip_q     <= strip_q + 1'b1;
                        rd_base_q   <= rd_base_q + ADDR_W'(STRIP_BYTES);
                        wr_base_q   <= wr_base_q + ADDR_W'(STRIP_BYTES);
                        fill_cnt_q  <= '0;
                        rd_launch_q <= 1'b1;
                        state_q     <= ST_READ;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    sts_burst_issuer #(
        .ADDR_W(ADDR_W), .TOTAL_BEATS(STRIP_WORDS),
        .MAX_BURST(MAX_BURST), .BYTES_PER_BEAT(BYTES_PER_WORD)
    ) u_rd_issuer (
        .clk(clk), .rst_n(rst_n), .launch(rd_launch_q), .base_addr(rd_base_q),
        .req_valid(rd_req_valid), .req_ready(rd_req_ready),
        .req_addr(rd_req_addr), .req_len(rd_req_len)
    );

    sts_burst_issuer #(
        .ADDR_W(ADDR_W), .TOTAL_BEATS(STRIP_WORDS),
        .MAX_BURST(MAX_BURST), .BYTES_PER_BEAT(BYTES_PER_WORD)
    ) u_wr_issuer (
        .clk(clk), .rst_n(rst_n), .launch(wr_launch_q), .base_addr(wr_base_q),
        .req_valid(wr_req_valid), .req_ready(wr_req_ready),
        .req_addr(wr_req_addr), .req_len(wr_req_len)
    );

    sts_strip_buffer #(.DEPTH(STRIP_WORDS), .DATA_W(DATA_W)) u_buf (
        .clk(clk), .wr_en(buf_wr_en), .wr_idx(buf_wr_idx), .wr_data(buf_wr_data),
        .rd_idx(buf_rd_idx), .rd_data(buf_rd_data)
    );

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!rd_req_valid && !wr_req_valid)); // R8
    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_valid |-> !rd_req_valid); // R9
    AST_OVL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_out_valid && !ovl_out_ready) |=> (ovl_out_valid && $stable(ovl_out_data))); // R4
    AST_WR_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data_valid && !wr_data_ready) |=> (wr_data_valid && $stable(wr_data))); // R5

endmodule

// File: tb/tb_strip_burst_seq.sv
// Bench for strip_burst_seq on a reduced frame: 3 strips of 4x9 words,
// bursts capped at 16 beats, 64-bit words. Memory and overlay engine are
// behavioural models driven at the falling edge.
module tb_strip_burst_seq;

    localparam int AW   = 32;
    localparam int DW   = 64;
    localparam int WPR  = 4;
    localparam int ROWS = 9;
    localparam int SC   = 3;
    localparam int MB   = 16;
    localparam int LW   = $clog2(MB + 1);
    localparam int SW   = WPR * ROWS;
    localparam int BPW  = DW / 8;
    localparam int TOT  = SW * SC;
    localparam logic [DW-1:0] KEY = 64'h0F1E_2D3C_4B5A_6978;

    // Frame vectors: input base, output base, stall mask, mid-frame disturbance.
    localparam int NVEC = 4;
    localparam logic [AW-1:0] VEC_IN  [NVEC] = '{32'h1000_0000, 32'h0000_4000, 32'h3000_0040, 32'h7FFF_F000};
    localparam logic [AW-1:0] VEC_OUT [NVEC] = '{32'h2000_0000, 32'h0008_0000, 32'h3000_8040, 32'h0000_0000};
    localparam logic [7:0]    VEC_MASK[NVEC] = '{8'hFF, 8'hB6, 8'h55, 8'hED};
    localparam bit            VEC_DIST[NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1};

    logic clk = 1'b0;
    logic rst_n, start;
    logic [AW-1:0] in_base, out_base;
    logic done;
    logic rd_req_valid, rd_req_ready, rd_data_valid;
    logic [AW-1:0] rd_req_addr;
    logic [LW-1:0] rd_req_len;
    logic [DW-1:0] rd_data;
    logic wr_req_valid, wr_req_ready, wr_data_valid, wr_data_ready;
    logic [AW-1:0] wr_req_addr;
    logic [LW-1:0] wr_req_len;
    logic [DW-1:0] wr_data;
    logic ovl_out_valid, ovl_out_ready, ovl_in_valid, ovl_in_ready;
    logic [DW-1:0] ovl_out_data, ovl_in_data;

    always #4 clk = ~clk;

    strip_burst_seq #(
        .ADDR_W(AW), .DATA_W(DW), .WORDS_PER_ROW(WPR), .ROWS_PER_STRIP(ROWS),
        .STRIP_COUNT(SC), .MAX_BURST(MB)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_base(in_base), .out_base(out_base),
        .done(done),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_req_len(rd_req_len),
        .rd_data_valid(rd_data_valid), .rd_data(rd_data),
        .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready),
        .wr_req_addr(wr_req_addr), .wr_req_len(wr_req_len),
        .wr_data_valid(wr_data_valid), .wr_data_ready(wr_data_ready), .wr_data(wr_data),
        .ovl_out_valid(ovl_out_valid), .ovl_out_ready(ovl_out_ready), .ovl_out_data(ovl_out_data),
        .ovl_in_valid(ovl_in_valid), .ovl_in_ready(ovl_in_ready), .ovl_in_data(ovl_in_data)
    );

    int n_chk = 0, n_fail = 0, cycles = 0;
    bit mon_en = 1'b0;
    logic [AW-1:0] cur_in, cur_out;
    logic [7:0] cur_mask;
    int cyc_n, rd_issued, rd_sent, ovl_acc, ovl_ret, wr_reqd, wr_beats, done_cnt;
    bit done_prev, rd_hold, wd_hold;
    logic [AW-1:0] rd_hold_addr;
    logic [LW-1:0] rd_hold_len;
    logic [DW-1:0] wd_hold_data;
    logic [DW-1:0] ovl_store [TOT];

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] src_word(input int beat);
        logic [AW-1:0] a;
        a = cur_in + AW'(beat * BPW);
        return {a, a ^ 32'hC3C3_5A5A};
    endfunction

    function automatic int exp_len(input int issued);
        int rem;
        rem = SW - (issued % SW);
        return (rem < MB) ? rem : MB;
    endfunction

    function automatic bit pat(input int ch);
        return cur_mask[(cyc_n + 3 * ch) % 8];
    endfunction

    // Behavioural memory, overlay engine and protocol monitor.
    always @(negedge clk) begin
        if (!rst_n || !mon_en) begin
            rd_req_ready = 1'b0; rd_data_valid = 1'b0; ovl_out_ready = 1'b0;
            ovl_in_valid = 1'b0; wr_req_ready = 1'b0; wr_data_ready = 1'b0;
            rd_hold = 1'b0; wd_hold = 1'b0; done_prev = 1'b0;
        end else begin
            cyc_n++;
            // R3: a request left pending must be unchanged now
            if (rd_hold)
                chk(rd_req_valid && rd_req_addr == rd_hold_addr && rd_req_len == rd_hold_len,
                    "R3 read request held", {32'b0, rd_req_addr}, {32'b0, rd_hold_addr});
            // R5: a stalled write beat must be unchanged now
            if (wd_hold)
                chk(wr_data_valid && wr_data == wd_hold_data, "R5 write beat held", wr_data, wd_hold_data);

            rd_req_ready = pat(0);
            if (rd_req_valid && rd_req_ready) begin
                chk(rd_req_addr == cur_in + AW'(rd_issued * BPW), "R2/R6 read address",
                    {32'b0, rd_req_addr}, {32'b0, cur_in + AW'(rd_issued * BPW)});
                chk(int'(rd_req_len) == exp_len(rd_issued), "R2 read length",
                    {{(DW-LW){1'b0}}, rd_req_len}, 64'(exp_len(rd_issued)));
                if (rd_issued > 0 && rd_issued % SW == 0)
                    chk(wr_beats == rd_issued, "R9 next read after write-back",
                        64'(wr_beats), 64'(rd_issued));
                rd_issued += int'(rd_req_len);
            end
            rd_hold = rd_req_valid && !rd_req_ready;
            rd_hold_addr = rd_req_addr;
            rd_hold_len = rd_req_len;

            if (rd_sent < rd_issued && pat(1)) begin
                rd_data_valid = 1'b1;
                rd_data = src_word(rd_sent);
                rd_sent++;
            end else begin
                rd_data_valid = 1'b0;
            end

            if (ovl_ret < ovl_acc && pat(3)) begin
                ovl_in_valid = 1'b1;
                ovl_in_data = ovl_store[ovl_ret] ^ KEY;
                if (ovl_in_ready) ovl_ret++;
            end else begin
                ovl_in_valid = 1'b0;
            end

            ovl_out_ready = pat(2);
            if (ovl_out_valid) begin
                chk(rd_sent >= (ovl_acc / SW + 1) * SW, "R4 overlay waits for full strip",
                    64'(rd_sent), 64'((ovl_acc / SW + 1) * SW));
                if (ovl_out_ready) begin
                    chk(ovl_out_data == src_word(ovl_acc), "R4 overlay word order",
                        ovl_out_data, src_word(ovl_acc));
                    ovl_store[ovl_acc] = ovl_out_data;
                    ovl_acc++;
                end
            end

            wr_req_ready = pat(4);
            if (wr_req_valid && wr_req_ready) begin
                chk(wr_req_addr == cur_out + AW'(wr_reqd * BPW), "R6 write address",
                    {32'b0, wr_req_addr}, {32'b0, cur_out + AW'(wr_reqd * BPW)});
                chk(int'(wr_req_len) == exp_len(wr_reqd), "R6 write length",
                    {{(DW-LW){1'b0}}, wr_req_len}, 64'(exp_len(wr_reqd)));
                if (wr_reqd % SW == 0)
                    chk(ovl_ret >= wr_reqd + SW, "R9 write after overlay",
                        64'(ovl_ret), 64'(wr_reqd + SW));
                wr_reqd += int'(wr_req_len);
            end

            wr_data_ready = pat(5);
            if (wr_data_valid && wr_data_ready) begin
                chk(wr_data == (src_word(wr_beats) ^ KEY), "R5 write data", wr_data,
                    src_word(wr_beats) ^ KEY);
                wr_beats++;
            end
            wd_hold = wr_data_valid && !wr_data_ready;
            wd_hold_data = wr_data;

            if (done) begin
                done_cnt++;
                chk(wr_beats == TOT && wr_reqd == TOT, "R7 done after last write",
                    64'(wr_beats), 64'(TOT));
                chk(!done_prev, "R7 done single cycle", 64'(done_prev), 64'(0));
            end
            done_prev = done;
        end
    end

    // Watchdog: a hung run is a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic clear_model(input int v);
        cur_in = VEC_IN[v]; cur_out = VEC_OUT[v]; cur_mask = VEC_MASK[v];
        cyc_n = 0; rd_issued = 0; rd_sent = 0; ovl_acc = 0; ovl_ret = 0;
        wr_reqd = 0; wr_beats = 0; done_cnt = 0;
    endtask

    task automatic check_quiet(input string tag);
        chk(!done && !rd_req_valid && !wr_req_valid && !wr_data_valid && !ovl_out_valid, tag,
            {59'b0, done, rd_req_valid, wr_req_valid, wr_data_valid, ovl_out_valid}, 64'(0));
    endtask

    task automatic run_frame(input int v);
        int late;
        @(negedge clk);
        clear_model(v);
        in_base = cur_in; out_base = cur_out; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (VEC_DIST[v]) begin
            repeat (40) @(negedge clk);
            // R8: restart and new bases mid-frame must be ignored
            start = 1'b1; in_base = ~cur_in; out_base = 32'hDEAD_0000;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_cnt == 0) @(negedge clk);
        late = 0;
        repeat (20) begin
            @(negedge clk);
            if (rd_req_valid || wr_req_valid) late++;
        end
        chk(late == 0, "R8 no activity after done", 64'(late), 64'(0));
        chk(done_cnt == 1, "R7 one done per frame", 64'(done_cnt), 64'(1));
        chk(rd_sent == TOT && ovl_ret == TOT, "R2 all strips read and processed",
            64'(rd_sent), 64'(TOT));
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; in_base = '0; out_base = '0;
        rd_data = '0; ovl_in_data = '0;
        clear_model(0);
        repeat (3) @(negedge clk);
        check_quiet("R1 outputs idle in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R1 outputs idle after reset");
        mon_en = 1'b1;

        for (int v = 0; v < NVEC; v++) run_frame(v);

        // R1: reset in the middle of a frame, then a full frame again
        @(negedge clk);
        clear_model(2);
        in_base = cur_in; out_base = cur_out; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        mon_en = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check_quiet("R1 mid-frame reset clears outputs");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R1 idle after mid-frame reset");
        mon_en = 1'b1;
        run_frame(0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule